// File: doc/BRIEF.md
# Alignment Fault Checker

This block inspects one memory-access request per cycle and decides whether the access must be refused with an alignment fault. A request carries an operation class, the low bits of the effective address, and the access size. It also carries the byte-order mode, the cache-inhibit and write-through attributes of the target page, and the locked and disabled state of the data cache. The misalignment rules differ by operation class and also depend on the page attributes, the cache state and the byte order. They do not depend on address and size alone.

Each accepted request produces exactly one registered result one cycle later. The result holds a fault flag, a per-rule cause vector, and the handler vector offset. A fetch or load/store pipeline uses the result to redirect to the alignment handler.

Top module: `misalign_guard`

## Requirements
- R1: `res_valid` is high in the cycle after each cycle in which `req_valid` is high, and low in the cycle after each cycle in which `req_valid` is low. Each request therefore yields exactly one result.
- R2: For the classes floating-point access (code 1), multiple-word (2), load-reserve (3), store-conditional (4) and external-control (5), a nonzero `req_addr_lo[1:0]` sets cause bit 0 and raises a fault.
- R3: For block-zero (code 7), cause bit 1 is set when the page is cache-inhibited or write-through.
- R4: For block-zero (code 7), cause bit 2 is set when the data cache is locked or disabled.
- R5: With `req_le` high, an access that is not naturally aligned sets cause bit 3. The size codes are 0 for byte (no bits checked), 1 for halfword (bit 0), 2 for word (bits 1:0) and 3 for doubleword (bits 2:0).
- R6: With `req_le` high, multiple-word (code 2) and string (code 6) requests set cause bit 4 at every address and size.
- R7: Ordinary accesses (code 0) and string accesses (code 6) in big-endian mode never fault. The page attributes and cache flags have no effect on any class except block-zero.
- R8: `res_fault` is high exactly when some cause bit is set. `res_vector` is 0x00600 when `res_fault` is high and zero otherwise.
- R9: After reset, `res_valid`, `res_fault`, `res_cause` and `res_vector` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_class | input | 3 | Operation class code |
| req_addr_lo | input | ADDR_LSB_W (3) | Low effective-address bits |
| req_size | input | SIZE_W (2) | Access size code |
| req_le | input | 1 | Little-endian mode |
| req_inhibit | input | 1 | Page is cache-inhibited |
| req_wthru | input | 1 | Page is write-through |
| dc_locked | input | 1 | Data cache locked |
| dc_disabled | input | 1 | Data cache disabled |
| res_valid | output | 1 | Result present |
| res_fault | output | 1 | Alignment fault raised |
| res_cause | output | 5 | Per-rule cause bits |
| res_vector | output | VEC_W (20) | Handler vector offset |

## Verification
The bench drives block-zero with each attribute and cache flag set alone and finds the mapping to cause bits 1 and 2. A design that mixed these up would report the wrong cause, or would miss a fault caused by the cache state alone. Little-endian string and multiple-word requests at aligned addresses are tested. A design that checked only alignment would pass them silently. Doubleword requests with only address bit 2 set separate a natural-alignment check from a word-only check. Big-endian ordinary and string requests with every attribute set must stay clean, which catches rules that leak across classes.

// File: rtl/mag_pkg.sv
`timescale 1ns/1ps
package mag_pkg;
   typedef enum logic [2:0] {
      OP_PLAIN   = 3'd0,
      OP_FLOAT   = 3'd1,
      OP_MULTI   = 3'd2,
      OP_LRESV   = 3'd3,
      OP_SCOND   = 3'd4,
      OP_XCTL    = 3'd5,
      OP_STRING  = 3'd6,
      OP_BZERO   = 3'd7
   } op_class_e;

   localparam int CAUSE_W      = 5;
   localparam int C_WORD       = 0;
   localparam int C_BZ_PAGE    = 1;
   localparam int C_BZ_CACHE   = 2;
   localparam int C_LE_NATURAL = 3;
   localparam int C_LE_FORBID  = 4;
endpackage

// File: rtl/mag_natural.sv
`timescale 1ns/1ps
module mag_natural #(
   parameter int ADDR_LSB_W = 3,
   parameter int SIZE_W     = 2
) (
   input  logic [ADDR_LSB_W-1:0] addr_lo,
   input  logic [SIZE_W-1:0]     size,
   output logic                  unnatural
);
   localparam int MAX_SIZE = (1 << SIZE_W) - 1;

   if (MAX_SIZE > ADDR_LSB_W) begin : g_bad_width
      $error("mag_natural: address field too narrow for largest size");
   end

   logic [ADDR_LSB_W-1:0] hit;

   for (genvar i = 0; i < ADDR_LSB_W; i++) begin : g_bit
      assign hit[i] = addr_lo[i] && (int'(size) > i);
   end

   assign unnatural = |hit;
endmodule

// File: rtl/mag_rules.sv
`timescale 1ns/1ps
module mag_rules
   import mag_pkg::*;
#(
   parameter int ADDR_LSB_W = 3,
   parameter int SIZE_W     = 2,
   parameter bit LE_SUPPORT = 1'b1
) (
   input  logic [2:0]            op_class,
   input  logic [ADDR_LSB_W-1:0] addr_lo,
   input  logic [SIZE_W-1:0]     size,
   input  logic                  le_mode,
   input  logic                  pg_inhibit,
   input  logic                  pg_wthru,
   input  logic                  dc_locked,
   input  logic                  dc_disabled,
   output logic [CAUSE_W-1:0]    cause
);
   op_class_e op;
   logic      word_class;
   logic      is_bz;
   logic      le_nat_bad;
   logic      le_forbid;

   assign op = op_class_e'(op_class);

   always_comb begin
      word_class = 1'b0;
      unique case (op)
         OP_FLOAT, OP_MULTI, OP_LRESV, OP_SCOND, OP_XCTL: word_class = 1'b1;
         default: word_class = 1'b0;
      endcase
   end

   assign is_bz = (op == OP_BZERO);

   if (LE_SUPPORT) begin : g_le
      logic unnatural;
      mag_natural #(
         .ADDR_LSB_W(ADDR_LSB_W),
         .SIZE_W    (SIZE_W)
      ) u_nat (
         .addr_lo  (addr_lo),
         .size     (size),
         .unnatural(unnatural)
      );
      assign le_nat_bad = le_mode && unnatural;
      assign le_forbid  = le_mode && ((op == OP_MULTI) || (op == OP_STRING));
   end else begin : g_no_le
      assign le_nat_bad = 1'b0;
      assign le_forbid  = 1'b0;
   end

   always_comb begin
      cause               = '0;
      cause[C_WORD]       = word_class && (|addr_lo[1:0]);
      cause[C_BZ_PAGE]    = is_bz && (pg_inhibit || pg_wthru);
      cause[C_BZ_CACHE]   = is_bz && (dc_locked || dc_disabled);
      cause[C_LE_NATURAL] = le_nat_bad;
      cause[C_LE_FORBID]  = le_forbid;
   end
endmodule

// File: rtl/misalign_guard.sv
`timescale 1ns/1ps
module misalign_guard
   import mag_pkg::*;
#(
   parameter int          ADDR_LSB_W = 3,
   parameter int          SIZE_W     = 2,
   parameter int          VEC_W      = 20,
   parameter logic [19:0] VEC_OFFSET = 20'h00600,
   parameter bit          LE_SUPPORT = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [2:0]            req_class,
   input  logic [ADDR_LSB_W-1:0] req_addr_lo,
   input  logic [SIZE_W-1:0]     req_size,
   input  logic                  req_le,
   input  logic                  req_inhibit,
   input  logic                  req_wthru,
   input  logic                  dc_locked,
   input  logic                  dc_disabled,
   output logic                  res_valid,
   output logic                  res_fault,
   output logic [CAUSE_W-1:0]    res_cause,
   output logic [VEC_W-1:0]      res_vector
);
   localparam logic [VEC_W-1:0] VEC_VAL = VEC_W'(VEC_OFFSET);

   if (ADDR_LSB_W < 3) begin : g_bad_addr
      $error("misalign_guard: ADDR_LSB_W must be at least 3");
   end
   if (VEC_W < 12) begin : g_bad_vec
      $error("misalign_guard: VEC_W too narrow for the handler offset");
   end

   logic [CAUSE_W-1:0] cause_d;

   mag_rules #(
      .ADDR_LSB_W(ADDR_LSB_W),
      .SIZE_W    (SIZE_W),
      .LE_SUPPORT(LE_SUPPORT)
   ) u_rules (
      .op_class   (req_class),
      .addr_lo    (req_addr_lo),
      .size       (req_size),
      .le_mode    (req_le),
      .pg_inhibit (req_inhibit),
      .pg_wthru   (req_wthru),
      .dc_locked  (dc_locked),
      .dc_disabled(dc_disabled),
      .cause      (cause_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_fault  <= 1'b0;
         res_cause  <= '0;
         res_vector <= '0;
      end else begin
         res_valid <= req_valid;
         if (req_valid) begin
            res_cause  <= cause_d;
            res_fault  <= |cause_d;
            res_vector <= (|cause_d) ? VEC_VAL : '0;
         end
      end
   end

   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> res_valid);
   a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !res_valid);
   a_r2_word_class: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_class >= 3'd1) && (req_class <= 3'd5) && (req_addr_lo[1:0] != 2'b00))
      |=> (res_fault && res_cause[C_WORD]));
   a_r3_bz_page: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_class == 3'd7) && (req_inhibit || req_wthru)) |=> res_cause[C_BZ_PAGE]);
   a_r6_le_forbid: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_le && ((req_class == 3'd2) || (req_class == 3'd6))) |=> res_fault);
   a_r7_plain_be_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_le && ((req_class == 3'd0) || (req_class == 3'd6))) |=> !res_fault);
   a_r8_vector: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_fault) |-> (res_vector == VEC_VAL));
endmodule

// File: tb/misalign_guard_tb.sv
`timescale 1ns/1ps
module misalign_guard_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [2:0] req_class = '0;
   logic [2:0] req_addr_lo = '0;
   logic [1:0] req_size = '0;
   logic       req_le = 1'b0;
   logic       req_inhibit = 1'b0;
   logic       req_wthru = 1'b0;
   logic       dc_locked = 1'b0;
   logic       dc_disabled = 1'b0;
   logic       res_valid;
   logic       res_fault;
   logic [4:0] res_cause;
   logic [19:0] res_vector;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   misalign_guard u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
      .req_addr_lo(req_addr_lo), .req_size(req_size), .req_le(req_le),
      .req_inhibit(req_inhibit), .req_wthru(req_wthru), .dc_locked(dc_locked),
      .dc_disabled(dc_disabled), .res_valid(res_valid), .res_fault(res_fault),
      .res_cause(res_cause), .res_vector(res_vector)
   );

   function automatic logic [4:0] exp_cause(input logic [2:0] c, input logic [2:0] a,
      input logic [1:0] sz, input logic le, input logic inh, input logic wt,
      input logic lk, input logic ds);
      logic [4:0] r;
      logic [2:0] mask;
      r = '0;
      case (sz)
         2'd0: mask = 3'b000;
         2'd1: mask = 3'b001;
         2'd2: mask = 3'b011;
         default: mask = 3'b111;
      endcase
      if (c >= 3'd1 && c <= 3'd5 && a[1:0] != 2'b00) r[0] = 1'b1;
      if (c == 3'd7 && (inh || wt)) r[1] = 1'b1;
      if (c == 3'd7 && (lk || ds)) r[2] = 1'b1;
      if (le && ((a & mask) != 3'b000)) r[3] = 1'b1;
      if (le && (c == 3'd2 || c == 3'd6)) r[4] = 1'b1;
      return r;
   endfunction

   function automatic string tag_of(input logic [4:0] c);
      if (c[4]) return "R6";
      if (c[3]) return "R5";
      if (c[2]) return "R4";
      if (c[1]) return "R3";
      if (c[0]) return "R2";
      return "R7";
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [2:0] c, input logic [2:0] a, input logic [1:0] sz,
      input logic le, input logic inh, input logic wt, input logic lk, input logic ds);
      logic [4:0] e;
      e = exp_cause(c, a, sz, le, inh, wt, lk, ds);
      req_valid = 1'b1; req_class = c; req_addr_lo = a; req_size = sz; req_le = le;
      req_inhibit = inh; req_wthru = wt; dc_locked = lk; dc_disabled = ds;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check("R1 valid", res_valid, 1);
      check(tag_of(e), res_cause, e);
      check("R8 fault", res_fault, |e);
      check("R8 vector", res_vector, (|e) ? 20'h00600 : 20'h0);
   endtask

   task automatic idle_check();
      @(posedge clk);
      @(negedge clk);
      check("R1 idle", res_valid, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9 valid", res_valid, 0);
      check("R9 fault", res_fault, 0);
      check("R9 cause", res_cause, 0);
      check("R9 vector", res_vector, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 no request", res_valid, 0);

      // R2 word-class misaligned and aligned
      send(3'd1, 3'b010, 2'd3, 0, 0, 0, 0, 0);
      send(3'd3, 3'b001, 2'd2, 0, 0, 0, 0, 0);
      send(3'd5, 3'b100, 2'd2, 0, 0, 0, 0, 0);
      // R3 page attribute, each alone
      send(3'd7, 3'b000, 2'd0, 0, 1, 0, 0, 0);
      send(3'd7, 3'b000, 2'd0, 0, 0, 1, 0, 0);
      // R4 cache state, each alone
      send(3'd7, 3'b000, 2'd0, 0, 0, 0, 1, 0);
      send(3'd7, 3'b000, 2'd0, 0, 0, 0, 0, 1);
      send(3'd7, 3'b000, 2'd0, 0, 0, 0, 0, 0);
      // R5 natural alignment in little-endian, doubleword with bit 2 only
      send(3'd0, 3'b100, 2'd3, 1, 0, 0, 0, 0);
      send(3'd0, 3'b100, 2'd2, 1, 0, 0, 0, 0);
      send(3'd0, 3'b111, 2'd0, 1, 0, 0, 0, 0);
      send(3'd0, 3'b001, 2'd1, 1, 0, 0, 0, 0);
      // R6 forbidden classes at aligned address
      send(3'd2, 3'b000, 2'd2, 1, 0, 0, 0, 0);
      send(3'd6, 3'b000, 2'd0, 1, 0, 0, 0, 0);
      // R7 big-endian plain/string with every attribute set
      send(3'd0, 3'b111, 2'd3, 0, 1, 1, 1, 1);
      send(3'd6, 3'b011, 2'd2, 0, 1, 1, 1, 1);
      send(3'd4, 3'b000, 2'd2, 0, 1, 1, 1, 1);
      idle_check();

      for (int i = 0; i < 600; i++) begin
         logic [31:0] r;
         r = $urandom;
         send(r[2:0], r[5:3], r[7:6], r[8], r[9] & r[10], r[11] & r[12],
              r[13] & r[14], r[15] & r[16]);
         if (r[20:18] == 3'd0) idle_check();
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule